// File: doc/BRIEF.md
# Interleaved Transmit Pattern Sequencer

This block supplies the codes for eight time-interleaved 8-bit DAC lanes. On every core clock cycle it presents one code per lane, so one word of eight symbols leaves the block each cycle. The symbols come from a pattern memory that a host fills with a symbol sequence that has already been equalized (pre-distorted). Playback reads one memory word per cycle. It starts at word 0 and wraps after a programmable last address, so the host can loop any sequence length up to the memory depth.

Fixed coupling errors repeat every 32 symbols, which is four core cycles. To cancel them, the block adds a signed correction to every symbol. The corrections sit in a table of four words with eight signed lanes each. A 2-bit phase counter picks the table word, and an alignment strobe from the reference clock domain resets that counter to phase 0. The counter runs all the time, so the correction stays phase-locked to the reference and does not depend on when playback starts. Each sum of code and correction is clipped to 0..255. Both tables are written through one port, and that port works only while playback is stopped.

Top module: `tx_pattern_seq`

## Requirements
- R1: While `rst` is high and after it is released, `dac_valid_o` is 0 and `dac_code_o` is all zero, until playback is started. The correction table resets to all zero.
- R2: If `run_i` is sampled high at a clock edge while playback is stopped, playback starts at that edge. The output word at the next edge is built from pattern word 0, and `dac_valid_o` is 1 there.
- R3: While playback runs, each edge advances the pattern address by one word. After the word whose address equals `len_m1_i`, the address returns to 0. With `len_m1_i` = 0, word 0 repeats on every cycle.
- R4: The correction word used for an output is the value of the phase counter in the cycle before that output. The counter counts 0,1,2,3,0,… on every cycle, whether or not playback runs. A high `ref_align_i` at an edge sets the counter to 0 at that edge.
- R5: Lane i occupies bits [8i+7:8i] of the pattern words, the correction words and `dac_code_o`. Correction lanes are 8-bit two's complement numbers.
- R6: Each output lane equals the pattern code (unsigned) plus the correction (signed). A sum below 0 is output as 0, and a sum above 255 is output as 255.
- R7: `wr_en_i` writes `wr_data_i` at an edge only while playback is stopped. With `wr_tgt_i` = 0 it writes pattern word `wr_addr_i`. With `wr_tgt_i` = 1 it writes correction word `wr_addr_i[1:0]`. Writes made during playback are dropped.
- R8: If `run_i` is sampled low while playing, playback stops at that edge. From the next edge on, `dac_valid_o` is 0 and `dac_code_o` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | Play while high, stop while low |
| len_m1_i | input | ADDR_W | Address of the last pattern word before wrap |
| ref_align_i | input | 1 | Reference alignment strobe, sets correction phase to 0 |
| wr_en_i | input | 1 | Table write enable, honoured only while stopped |
| wr_tgt_i | input | 1 | Write target: 0 pattern memory, 1 correction table |
| wr_addr_i | input | ADDR_W | Write word address |
| wr_data_i | input | 64 | Write data, eight 8-bit lanes |
| dac_code_o | output | 64 | Eight lane codes, lane 0 in the low byte |
| dac_valid_o | output | 1 | High while the codes carry played symbols |

## Verification
The hardest case to reach is the saturation boundary on every lane combined with every correction phase. The bench reaches it by making each pattern code 0..255 appear exactly once across 32 words. It then reloads the correction table eight times so that the signed corrections together cover -128..127, and an alignment strobe lands at a different cycle in each pass. A second hard case is a write during playback. It is shown to be dropped by stopping and replaying the same words, and the replayed output is compared with the unchanged content.

// File: rtl/tx_seq_pkg.sv
`timescale 1ns/1ps
package tx_seq_pkg;
    localparam int LANES    = 8;
    localparam int CODE_W   = 8;
    localparam int PHASES   = 4;
    localparam int PH_W     = $clog2(PHASES);
    localparam int WORD_W   = LANES * CODE_W;

    typedef logic        [CODE_W-1:0] code_t;
    typedef logic signed [CODE_W-1:0] corr_t;
    typedef code_t [LANES-1:0] code_word_t;
    typedef logic  [LANES-1:0][CODE_W-1:0] corr_word_t;

    typedef enum logic { TGT_PATTERN = 1'b0, TGT_CORR = 1'b1 } wr_tgt_e;

    typedef struct packed {
        logic       valid;
        code_word_t codes;
    } tx_out_t;

    // Unsigned code plus signed correction, clipped to the code range.
    function automatic code_t sat_add(code_t code, corr_t corr);
        logic signed [CODE_W+1:0] sum;
        sum = $signed({2'b00, code}) + $signed({{2{corr[CODE_W-1]}}, corr});
        if (sum[CODE_W+1])
            return '0;
        else if (sum[CODE_W])
            return '1;
        else
            return sum[CODE_W-1:0];
    endfunction
endpackage

// File: rtl/tx_pat_mem.sv
`timescale 1ns/1ps
module tx_pat_mem
    import tx_seq_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  code_word_t        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output code_word_t        rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    code_word_t store [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            store[waddr] <= wdata;
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/tx_corr_table.sv
`timescale 1ns/1ps
module tx_corr_table
    import tx_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [PH_W-1:0] widx,
    input  corr_word_t      wdata,
    input  logic [PH_W-1:0] rsel,
    output corr_word_t      rdata
);
    corr_word_t tbl [PHASES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < PHASES; p++)
                tbl[p] <= '0;
        end else if (we) begin
            tbl[widx] <= wdata;
        end
    end

    assign rdata = tbl[rsel];
endmodule

// File: rtl/tx_lane_sat.sv
`timescale 1ns/1ps
module tx_lane_sat
    import tx_seq_pkg::*;
(
    input  code_word_t codes_i,
    input  corr_word_t corr_i,
    output code_word_t codes_o
);
    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        assign codes_o[ln] = sat_add(codes_i[ln], corr_t'(corr_i[ln]));
    end
endmodule

// File: rtl/tx_pattern_seq.sv
`timescale 1ns/1ps
module tx_pattern_seq
    import tx_seq_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_i,
    input  logic [ADDR_W-1:0] len_m1_i,
    input  logic              ref_align_i,
    input  logic              wr_en_i,
    input  logic              wr_tgt_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [63:0]       wr_data_i,
    output logic [63:0]       dac_code_o,
    output logic              dac_valid_o
);
    logic              act_q;
    logic [ADDR_W-1:0] addr_q;
    logic [PH_W-1:0]   phase_q;
    tx_out_t           out_q;

    code_word_t pat_word;
    corr_word_t corr_word;
    code_word_t sum_word;

    logic    wr_ok;
    wr_tgt_e tgt;

    assign tgt   = wr_tgt_e'(wr_tgt_i);
    assign wr_ok = wr_en_i && !act_q;

    tx_pat_mem #(.ADDR_W(ADDR_W)) u_pat (
        .clk   (clk),
        .we    (wr_ok && tgt == TGT_PATTERN),
        .waddr (wr_addr_i),
        .wdata (code_word_t'(wr_data_i)),
        .raddr (addr_q),
        .rdata (pat_word)
    );

    tx_corr_table u_corr (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_ok && tgt == TGT_CORR),
        .widx  (wr_addr_i[PH_W-1:0]),
        .wdata (corr_word_t'(wr_data_i)),
        .rsel  (phase_q),
        .rdata (corr_word)
    );

    tx_lane_sat u_sat (
        .codes_i (pat_word),
        .corr_i  (corr_word),
        .codes_o (sum_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q   <= 1'b0;
            addr_q  <= '0;
            phase_q <= '0;
            out_q   <= '0;
        end else begin
            phase_q <= ref_align_i ? '0 : phase_q + 1'b1;
            act_q   <= run_i;
            if (!act_q || addr_q == len_m1_i)
                addr_q <= '0;
            else
                addr_q <= addr_q + 1'b1;
            out_q.valid <= act_q;
            out_q.codes <= act_q ? sum_word : '0;
        end
    end

    assign dac_code_o  = out_q.codes;
    assign dac_valid_o = out_q.valid;
endmodule

// File: rtl/tx_pattern_seq_chk.sv
`timescale 1ns/1ps
module tx_pattern_seq_chk #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              run_i,
    input logic [ADDR_W-1:0] len_m1_i,
    input logic              ref_align_i,
    input logic              act_q,
    input logic [ADDR_W-1:0] addr_q,
    input logic [1:0]        phase_q,
    input logic [63:0]       dac_code_o,
    input logic              dac_valid_o
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !dac_valid_o |-> dac_code_o == '0);                                   // R8
    AST_STOP_DROPS_VALID: assert property (@(posedge clk) disable iff (rst)
        !act_q |=> !dac_valid_o);                                             // R8
    AST_PLAY_RAISES_VALID: assert property (@(posedge clk) disable iff (rst)
        act_q |=> dac_valid_o);                                               // R2
    AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!act_q && run_i) |=> (act_q && addr_q == '0));                       // R2
    AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (rst)
        (act_q && run_i && addr_q == len_m1_i) |=> addr_q == '0);             // R3
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (act_q && run_i && addr_q != len_m1_i) |=> addr_q == $past(addr_q) + 1'b1); // R3
    AST_PHASE_ALIGN: assert property (@(posedge clk) disable iff (rst)
        ref_align_i |=> phase_q == 2'd0);                                     // R4
    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
        !ref_align_i |=> phase_q == $past(phase_q) + 2'd1);                   // R4
endmodule

bind tx_pattern_seq tx_pattern_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .run_i       (run_i),
    .len_m1_i    (len_m1_i),
    .ref_align_i (ref_align_i),
    .act_q       (act_q),
    .addr_q      (addr_q),
    .phase_q     (phase_q),
    .dac_code_o  (dac_code_o),
    .dac_valid_o (dac_valid_o)
);

// File: tb/tb_tx_pattern_seq.sv
`timescale 1ns/1ps
module tb_tx_pattern_seq;
    localparam int AW    = 6;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst;
    logic          run_i;
    logic [AW-1:0] len_m1_i;
    logic          ref_align_i;
    logic          wr_en_i;
    logic          wr_tgt_i;
    logic [AW-1:0] wr_addr_i;
    logic [63:0]   wr_data_i;
    logic [63:0]   dac_code_o;
    logic          dac_valid_o;

    tx_pattern_seq #(.ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .run_i(run_i), .len_m1_i(len_m1_i),
        .ref_align_i(ref_align_i), .wr_en_i(wr_en_i), .wr_tgt_i(wr_tgt_i),
        .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .dac_code_o(dac_code_o), .dac_valid_o(dac_valid_o)
    );

    always #4 clk = ~clk;

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 1'b0;
    string tag    = "R1";

    // Bench-side model of the requirements
    bit  m_act = 1'b0;
    int  m_addr = 0;
    int  m_ph = 0;
    int  m_pat [DEPTH][8];
    int  m_corr [4][8];

    function automatic int clamp(int v);
        if (v < 0)   return 0;
        if (v > 255) return 255;
        return v;
    endfunction

    function automatic int sbyte(logic [7:0] b);
        return (b > 127) ? int'(b) - 256 : int'(b);
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // One clock: inputs were driven at the preceding falling edge.
    task automatic cyc();
        logic [63:0] e_code;
        bit          e_val;
        @(posedge clk);
        e_val  = m_act;
        e_code = '0;
        if (m_act)
            for (int l = 0; l < 8; l++)
                e_code[8*l +: 8] = 8'(clamp(m_pat[m_addr][l] + m_corr[m_ph][l]));
        if (wr_en_i && !m_act) begin
            for (int l = 0; l < 8; l++) begin
                if (wr_tgt_i) m_corr[wr_addr_i % 4][l] = sbyte(wr_data_i[8*l +: 8]);
                else          m_pat[wr_addr_i][l]      = int'(wr_data_i[8*l +: 8]);
            end
        end
        m_ph   = ref_align_i ? 0 : (m_ph + 1) % 4;
        m_addr = !m_act ? 0 : ((m_addr == int'(len_m1_i)) ? 0 : m_addr + 1);
        m_act  = run_i;
        #1;
        chk({tag, " valid"}, {63'd0, dac_valid_o}, {63'd0, e_val});
        chk({tag, " code"}, dac_code_o, e_code);
        @(negedge clk);
    endtask

    task automatic wr(bit tgt, int addr, logic [63:0] data);
        wr_en_i = 1'b1; wr_tgt_i = tgt; wr_addr_i = AW'(addr); wr_data_i = data;
        cyc();
        wr_en_i = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] d;
        rst = 1'b1; run_i = 1'b0; len_m1_i = 31; ref_align_i = 1'b0;
        wr_en_i = 1'b0; wr_tgt_i = 1'b0; wr_addr_i = '0; wr_data_i = '0;
        for (int p = 0; p < 4; p++) for (int l = 0; l < 8; l++) m_corr[p][l] = 0;
        for (int w = 0; w < DEPTH; w++) for (int l = 0; l < 8; l++) m_pat[w][l] = 0;

        // R1: quiet during and after reset
        repeat (3) @(negedge clk);
        chk("R1 reset valid", {63'd0, dac_valid_o}, 64'd0);
        chk("R1 reset code", dac_code_o, 64'd0);
        rst = 1'b0;
        tag = "R1";
        idle(3);

        // R7 R5: load all pattern words while stopped; lane l at bits 8l+7:8l
        tag = "R7 load";
        for (int w = 0; w < DEPTH; w++) begin
            for (int l = 0; l < 8; l++)
                d[8*l +: 8] = (w < 32) ? 8'(w*8 + l) : 8'(w*37 + l*11);
            wr(1'b0, w, d);
        end

        // R2 R4 R5 R6: saturation sweep, corrections cover -128..127
        for (int g = 0; g < 8; g++) begin
            tag = "R6 R5 sweep";
            for (int p = 0; p < 4; p++) begin
                for (int l = 0; l < 8; l++)
                    d[8*l +: 8] = 8'(g*32 + p*8 + l - 128);
                wr(1'b1, p, d);
            end
            tag = "R4 align";
            ref_align_i = 1'b1; cyc(); ref_align_i = 1'b0;
            tag = "R2 start";
            run_i = 1'b1;
            for (int c = 0; c < 40; c++) begin
                tag = "R6 R4 R3 play";
                ref_align_i = (c == 10 + g);
                cyc();
            end
            ref_align_i = 1'b0;
            tag = "R8 stop";
            run_i = 1'b0;
            idle(3);
        end

        // R3: different wrap lengths
        tag = "R3 len0";
        len_m1_i = 0; run_i = 1'b1; idle(6); run_i = 1'b0; idle(2);
        tag = "R3 len5";
        len_m1_i = 5; run_i = 1'b1; idle(15); run_i = 1'b0; idle(2);
        tag = "R3 full";
        len_m1_i = AW'(DEPTH - 1); run_i = 1'b1; idle(DEPTH + 6); run_i = 1'b0; idle(2);

        // R2: single-cycle run pulse gives one word 0 output
        tag = "R2 pulse";
        len_m1_i = 7; run_i = 1'b1; cyc(); run_i = 1'b0; idle(3);

        // R7: writes during playback are dropped, checked by replay
        tag = "R7 busy write";
        run_i = 1'b1; idle(2);
        wr(1'b0, 0, 64'hFFFF_FFFF_FFFF_FFFF);
        wr(1'b0, 3, 64'h0);
        wr(1'b1, 0, 64'h7F7F_7F7F_7F7F_7F7F);
        wr(1'b1, 2, 64'h8080_8080_8080_8080);
        idle(4);
        run_i = 1'b0; idle(2);
        tag = "R7 replay";
        run_i = 1'b1; idle(20); run_i = 1'b0;

        // R8: stays quiet after stop
        tag = "R8 quiet";
        idle(5);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule